// File: doc/BRIEF.md
# Dual-Rate I2C Bus Clock Tick Generator

This block produces the half-bit timing ticks that an I2C master uses to toggle and sample its clock line. Three counters run in a cascade from the source clock. The first is a fixed pre-divider. The second is a sample counter that advances once per pre-divider wrap. The third is a step counter that advances once per sample-counter wrap. One half-bit tick is issued each time all three wrap in the same cycle. A half period therefore lasts `P × S × T` source cycles, which gives a bus frequency of `f_src / (2 × P × S × T)`. Every count is programmed as its value minus one.

The block holds two timing sets. The standard/fast set is used at start-up and for the master-code phase. The high-speed set takes over when the high-speed mode selector is armed and the master reports that the master code has been sent. At that switch the half period restarts from zero. The configuration is captured only while the generator is idle, so a transfer always runs on the timing it started with. Dropping the enable returns the block to the standard/fast set.

Top module: `sclgen_top`

## Requirements
- R1: While and right after reset, `halfTick` and `hsActive` are 0.
- R2: After `enable` rises, with `hsActive` low, the first `halfTick` appears N = (preDivM1+1)·(normSampM1+1)·(normStepM1+1) rising edges after the first edge that samples `enable` high, counting that edge.
- R3: While enabled and not switching, consecutive `halfTick` pulses are exactly N source cycles apart; each pulse lasts one cycle when N > 1, and `halfTick` is high every cycle when N = 1.
- R4: While `enable` is low, `halfTick` stays 0 and `hsActive` returns to 0 on the next edge; the counters restart from zero.
- R5: When `enable` is high, `hsModeSel` = 2'b11 and `hsActive` is 0, a `masterCodeDone` pulse sets `hsActive` on that edge and restarts the half period. No tick occurs on that edge.
- R6: In high-speed mode the tick spacing is M = (preDivM1+1)·(hsSampM1+1)·(hsStepM1+1). The first tick follows M edges after the switching edge.
- R7: With `hsModeSel` other than 2'b11, `masterCodeDone` is ignored: `hsActive` stays 0 and the standard tick spacing continues without restart.
- R8: Changes to any timing input while `enable` is high do not alter the running tick spacing.
- R9: Once set, `hsActive` stays high while `enable` is high; further `masterCodeDone` pulses do not restart the period.
- R10: A `masterCodeDone` pulse while `enable` is low is ignored; a later enable starts in standard/fast mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the generator; low means idle and capture configuration |
| preDivM1 | input | PRE_W | Pre-divider value minus one |
| normSampM1 | input | SAMP_W | Standard/fast sample count minus one (1..8) |
| normStepM1 | input | STEP_W | Standard/fast step count minus one (1..64) |
| hsSampM1 | input | SAMP_W | High-speed sample count minus one |
| hsStepM1 | input | HS_STEP_W | High-speed step count minus one (1..8) |
| hsModeSel | input | 2 | 2'b11 arms high-speed mode, other values disarm it |
| masterCodeDone | input | 1 | One-cycle pulse: master code has been sent |
| halfTick | output | 1 | One-cycle pulse at each half-bit boundary |
| hsActive | output | 1 | High while the high-speed timing set is in use |

## Verification
A counter stuck or wrapping at the wrong limit shows at the ports as a tick spacing that differs from the product of the programmed counts. That difference appears at the first tick after enable, within one half period. A switch made with the wrong restart or timing set shows as a first high-speed gap that is off by a full period, or as the standard spacing persisting. Shadow capture that leaks while running shows up within one period after the inputs change. Random configurations, including the minimum and maximum products, are compared against gaps computed from the counts.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;
  typedef struct packed {
    logic clr;   // force all counters to zero this cycle
    logic run;   // advance the cascade
  } ctrlStrobe_t;
  localparam int NUM_STAGES = 3;  // pre-divider, sample, step
endpackage

// File: rtl/sclgen_ctrl.sv
module sclgen_ctrl
  import sclgen_pkg::*;
#(
  parameter int PRE_W       = 4,
  parameter int SAMP_W      = 3,
  parameter int STEP_W      = 6,
  parameter int HS_STEP_W   = 3,
  parameter int PRE_DEFAULT = 5,
  parameter int CW          = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [PRE_W-1:0]  preDivM1,
  input  logic [SAMP_W-1:0] normSampM1,
  input  logic [STEP_W-1:0] normStepM1,
  input  logic [SAMP_W-1:0] hsSampM1,
  input  logic [HS_STEP_W-1:0] hsStepM1,
  input  logic [1:0]        hsModeSel,
  input  logic              masterCodeDone,
  output ctrlStrobe_t       strobe,
  output logic [CW-1:0]     limPre,
  output logic [CW-1:0]     limSamp,
  output logic [CW-1:0]     limStep,
  output logic              hsActive
);
  logic [PRE_W-1:0]     preShadow;
  logic [SAMP_W-1:0]    normSampShadow;
  logic [STEP_W-1:0]    normStepShadow;
  logic [SAMP_W-1:0]    hsSampShadow;
  logic [HS_STEP_W-1:0] hsStepShadow;
  logic                 hsArmed;
  logic                 switchNow;

  assign switchNow = enable && masterCodeDone && hsArmed && !hsActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preShadow      <= PRE_W'(PRE_DEFAULT - 1);
      normSampShadow <= '0;
      normStepShadow <= '0;
      hsSampShadow   <= '0;
      hsStepShadow   <= '0;
      hsArmed        <= 1'b0;
      hsActive       <= 1'b0;
    end else if (!enable) begin
      preShadow      <= preDivM1;
      normSampShadow <= normSampM1;
      normStepShadow <= normStepM1;
      hsSampShadow   <= hsSampM1;
      hsStepShadow   <= hsStepM1;
      hsArmed        <= (hsModeSel == 2'b11);
      hsActive       <= 1'b0;
    end else if (switchNow) begin
      hsActive <= 1'b1;
    end
  end

  always_comb begin
    strobe.run = enable;
    strobe.clr = !enable || switchNow;
    limPre     = CW'(preShadow);
    limSamp    = hsActive ? CW'(hsSampShadow) : CW'(normSampShadow);
    limStep    = hsActive ? CW'(hsStepShadow) : CW'(normStepShadow);
  end
endmodule

// File: rtl/sclgen_path.sv
module sclgen_path
  import sclgen_pkg::*;
#(
  parameter int CW     = 6,
  parameter int STAGES = NUM_STAGES
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobe_t                strobe,
  input  logic [STAGES-1:0][CW-1:0]  lims,
  output logic                       halfTick
);
  logic [STAGES:0]   carry;
  logic [STAGES-1:0] wrapAt;

  assign carry[0] = strobe.run;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [CW-1:0] count;
    assign wrapAt[i]  = (count == lims[i]);
    assign carry[i+1] = carry[i] && wrapAt[i];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          count <= '0;
      else if (strobe.clr) count <= '0;
      else if (carry[i])  count <= wrapAt[i] ? '0 : count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) halfTick <= 1'b0;
    else       halfTick <= !strobe.clr && carry[STAGES];
  end
endmodule

// File: rtl/sclgen_top.sv
module sclgen_top
  import sclgen_pkg::*;
#(
  parameter int PRE_W       = 4,
  parameter int SAMP_W      = 3,
  parameter int STEP_W      = 6,
  parameter int HS_STEP_W   = 3,
  parameter int PRE_DEFAULT = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic [PRE_W-1:0]     preDivM1,
  input  logic [SAMP_W-1:0]    normSampM1,
  input  logic [STEP_W-1:0]    normStepM1,
  input  logic [SAMP_W-1:0]    hsSampM1,
  input  logic [HS_STEP_W-1:0] hsStepM1,
  input  logic [1:0]           hsModeSel,
  input  logic                 masterCodeDone,
  output logic                 halfTick,
  output logic                 hsActive
);
  localparam int CW_A = (PRE_W > SAMP_W) ? PRE_W : SAMP_W;
  localparam int CW_B = (STEP_W > HS_STEP_W) ? STEP_W : HS_STEP_W;
  localparam int CW   = (CW_A > CW_B) ? CW_A : CW_B;

  ctrlStrobe_t strobe;
  logic [CW-1:0] limPre, limSamp, limStep;
  logic [NUM_STAGES-1:0][CW-1:0] lims;

  assign lims = {limStep, limSamp, limPre};

  sclgen_ctrl #(
    .PRE_W(PRE_W), .SAMP_W(SAMP_W), .STEP_W(STEP_W),
    .HS_STEP_W(HS_STEP_W), .PRE_DEFAULT(PRE_DEFAULT), .CW(CW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .preDivM1(preDivM1),
    .normSampM1(normSampM1), .normStepM1(normStepM1),
    .hsSampM1(hsSampM1), .hsStepM1(hsStepM1), .hsModeSel(hsModeSel),
    .masterCodeDone(masterCodeDone), .strobe(strobe),
    .limPre(limPre), .limSamp(limSamp), .limStep(limStep),
    .hsActive(hsActive)
  );

  sclgen_path #(.CW(CW), .STAGES(NUM_STAGES)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lims(lims),
    .halfTick(halfTick)
  );
endmodule

// File: rtl/sclgen_checker.sv
module sclgen_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic masterCodeDone,
  input logic halfTick,
  input logic hsActive
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!halfTick && !hsActive)); // R4
  AST_HS_FROM_CODE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsActive) |-> $past(masterCodeDone && enable)); // R5
  AST_SWITCH_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsActive) |-> !halfTick); // R5
  AST_HS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (hsActive && enable) |=> hsActive); // R9
endmodule

bind sclgen_top sclgen_checker u_chk (
  .clk(clk), .rstN(rstN), .enable(enable),
  .masterCodeDone(masterCodeDone), .halfTick(halfTick), .hsActive(hsActive)
);

// File: tb/tb_sclgen_top.sv
module tb_sclgen_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [3:0] preDivM1 = '0;
  logic [2:0] normSampM1 = '0;
  logic [5:0] normStepM1 = '0;
  logic [2:0] hsSampM1 = '0;
  logic [2:0] hsStepM1 = '0;
  logic [1:0] hsModeSel = '0;
  logic masterCodeDone = 1'b0;
  logic halfTick, hsActive;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cycles++;

  sclgen_top dut (
    .clk(clk), .rstN(rstN), .enable(enable), .preDivM1(preDivM1),
    .normSampM1(normSampM1), .normStepM1(normStepM1),
    .hsSampM1(hsSampM1), .hsStepM1(hsStepM1), .hsModeSel(hsModeSel),
    .masterCodeDone(masterCodeDone), .halfTick(halfTick), .hsActive(hsActive)
  );

  function automatic int gap(int p, int s, int t);
    return p * s * t;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitTick(output int c);
    c = 0;
    do begin
      @(posedge clk); @(negedge clk);
      c++;
    end while (!halfTick && c < 6000);
  endtask

  task automatic pulseWait(output int c, output bit hsSeen);
    masterCodeDone = 1'b1;
    c = 0;
    hsSeen = 0;
    do begin
      @(posedge clk); @(negedge clk);
      if (c == 0) hsSeen = hsActive;
      masterCodeDone = 1'b0;
      c++;
    end while (!halfTick && c < 6000);
  endtask

  task automatic configure(int p, int s, int t, int hs, int ht, int sel);
    enable = 1'b0;
    preDivM1 = 4'(p - 1); normSampM1 = 3'(s - 1); normStepM1 = 6'(t - 1);
    hsSampM1 = 3'(hs - 1); hsStepM1 = 3'(ht - 1); hsModeSel = 2'(sel);
    repeat (2) @(negedge clk);
  endtask

  task automatic runTrial(int p, int s, int t, int hs, int ht, int sel);
    int c, n, m;
    bit hsSeen;
    n = gap(p, s, t);
    m = gap(p, hs, ht);
    configure(p, s, t, hs, ht, sel);
    enable = 1'b1;
    waitTick(c);
    check(c == n, "R2 first tick", c, n);
    waitTick(c);
    check(c == n, "R3 tick spacing", c, n);
    // R8: disturb inputs while running
    preDivM1 = 4'($urandom_range(0, 4)); normSampM1 = 3'($urandom);
    normStepM1 = 6'($urandom); hsSampM1 = 3'($urandom); hsStepM1 = 3'($urandom);
    waitTick(c);
    check(c == n, "R8 running config frozen", c, n);
    pulseWait(c, hsSeen);
    if (sel == 3) begin
      check(hsSeen == 1'b1, "R5 hsActive set", int'(hsSeen), 1);
      check(c == m + 1, "R5 restart at switch", c, m + 1);
      waitTick(c);
      check(c == m, "R6 high-speed spacing", c, m);
      pulseWait(c, hsSeen);
      check(c == m && hsActive, "R9 repeated code ignored", c, m);
    end else begin
      check(c == n && !hsActive, "R7 code ignored when disarmed", c, n);
    end
    enable = 1'b0;
    @(negedge clk);
    check(!hsActive && !halfTick, "R4 idle clears", int'(hsActive), 0);
    repeat (3) @(negedge clk);
    check(!halfTick, "R4 idle no tick", int'(halfTick), 0);
  endtask

  initial begin
    int c;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!halfTick && !hsActive, "R1 reset state", int'(halfTick | hsActive), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!halfTick && !hsActive, "R1 after reset", int'(halfTick | hsActive), 0);

    // minimum product: tick every cycle
    configure(1, 1, 1, 1, 1, 0);
    enable = 1'b1;
    waitTick(c); check(c == 1, "R2 N=1 first", c, 1);
    waitTick(c); check(c == 1, "R3 N=1 continuous", c, 1);
    enable = 1'b0;
    // single-cycle pulse width
    configure(1, 2, 1, 1, 1, 0);
    enable = 1'b1;
    waitTick(c);
    @(negedge clk);
    check(!halfTick, "R3 pulse one cycle", int'(halfTick), 0);
    // R10: code while idle
    configure(2, 2, 3, 2, 2, 3);
    masterCodeDone = 1'b1; @(negedge clk); masterCodeDone = 1'b0;
    enable = 1'b1;
    waitTick(c);
    check(c == 12 && !hsActive, "R10 idle code ignored", c, 12);
    // maximum product
    runTrial(5, 8, 64, 8, 8, 3);
    runTrial(1, 1, 2, 1, 1, 3);
    runTrial(3, 4, 5, 2, 3, 1);
    for (int i = 0; i < 8; i++) begin
      runTrial($urandom_range(1, 5), $urandom_range(1, 8), $urandom_range(1, 32),
               $urandom_range(1, 8), $urandom_range(1, 8),
               ($urandom_range(0, 2) != 0) ? 3 : $urandom_range(0, 2));
    end
    done = 1;
  end

  initial begin
    wait (done || cycles >= 190000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule